// File: doc/BRIEF.md
# Low-Power Wake UART Receiver

An asynchronous serial receive channel meant to keep working while the core clock is gated off. Once software opens the channel with a start trigger, the receiver watches a synchronized copy of the serial input. When a start bit arrives it confirms the bit at mid-bit, shifts in 8 or 9 data bits LSB first, optionally checks a parity bit, samples the stop bit, and loads the data register. While the wake-mode enable is set, an internal clock request is raised for the duration of the frame, so the clock controller can supply a clock and the receive-complete interrupt can wake the system.

Error handling is configurable. A routing bit sends frames with parity, framing or overrun errors to a separate error interrupt instead of the receive-complete interrupt. A suppression bit stops the three sticky error flags from setting and gates the error interrupt entirely. Software clears stale flags with a clear strobe before it enters wake mode. Bit timing comes from a fixed divider of the block clock.

Top module: `wake_uart_rx`

## Requirements
- R1: Frames are received only while the channel is open; `chan_start` opens it and `chan_stop` closes it (stop wins when both pulse together). Once the channel is closed, the receiver returns to idle within one cycle and loads nothing.
- R2: A frame is one low start bit, then 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1) LSB first, then an optional parity bit, then one stop bit. Each bit lasts `DIV` clocks. `rdata` holds bits [7:0] with bit 8 zero in 8-bit mode, or bits [8:0] in 9-bit mode.
- R3: With `err_suppress`=1, a parity, framing or overrun error sets no flag and raises no `err_irq`.
- R4: `par_mode` 2'b00 means no parity bit, 2'b01 means even, 2'b10 means odd, and 2'b11 is treated as no parity. A mismatching parity bit is a parity error.
- R5: A low level sampled at the stop bit is a framing error. The data is still loaded.
- R6: If a frame completes while the previous data is unread, the new data overwrites `rdata`, and `overrun_err` sets unless suppression is on. A `data_read` pulse marks the data as read.
- R7: A completed frame gives a one-cycle pulse on exactly one interrupt. The pulse is on `err_irq` when `err_route`=1 and an unsuppressed error occurred, and on `rx_irq` otherwise. The pulse comes in the cycle after the stop-bit sample.
- R8: With `wake_en`=1, `clk_req` goes high two clocks after the first low input sample, counting from the first clock edge that sees the line low. It stays high through the frame and goes low one cycle after `rdata` is loaded. With `wake_en`=0, `clk_req` stays low.
- R9: A start bit that reads high at its mid-bit sample aborts the frame. The receiver returns to idle, drops `clk_req`, raises no interrupt, and leaves `rdata` unchanged.
- R10: The error flags are sticky until a `flag_clear` pulse. A new error in the same cycle as the clear wins.
- R11: After reset, `rdata`, all flags, both interrupts and `clk_req` are 0, and the channel is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| chan_start | input | 1 | Pulse: open the channel |
| chan_stop | input | 1 | Pulse: close the channel |
| wake_en | input | 1 | Wake-capable mode enable |
| err_route | input | 1 | Route errored frames to `err_irq` |
| err_suppress | input | 1 | Suppress error flags and error interrupt |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_mode | input | 2 | Parity mode (none/even/odd) |
| data_read | input | 1 | Pulse: software has read `rdata` |
| flag_clear | input | 1 | Pulse: clear the error flags |
| rdata | output | 9 | Received data |
| parity_err | output | 1 | Sticky parity error flag |
| frame_err | output | 1 | Sticky framing error flag |
| overrun_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive-complete interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| clk_req | output | 1 | Internal clock request |

## Verification
On every cycle, the assertions check these properties:
- The two interrupts are never high together, and each lasts exactly one cycle.
- An error flag never rises while suppression was set.
- `err_irq` only occurs with routing on and suppression off.
- Overrun only rises over unread data.
- A closed channel drops the clock request.
- The sequencer always leaves its done state for idle.

The bench scenarios are the only way to show the rest:
- the data values and the bit order
- the parity arithmetic for each mode
- the exact edge on which the clock request rises and falls
- the abort on a false start
- the overwrite order in an overrun

// File: rtl/wurx_pkg.sv
// Shared types for the wake UART receiver.
// Assumes: at most 9 data bits per frame.
package wurx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_DONE
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [8:0] data;
        logic       par_err;
        logic       frm_err;
    } rx_result_t;
endpackage

// File: rtl/wurx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so every stage resets to 1.
module wurx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/wurx_baud.sv
// Bit-timing divider. It produces a tick after DIV clocks, or after DIV/2
// clocks when half is set (used for the start-bit mid-point).
// Assumes: DIV >= 4 and even. The count restarts on clr and on each tick.
module wurx_baud #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic half,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] FULL_LIM = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF_LIM = CW'(DIV / 2 - 1);

    logic [CW-1:0] cnt;

    assign tick = !clr && (cnt == (half ? HALF_LIM : FULL_LIM));

    // Count clocks inside the current bit, restarting on clear or tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wurx_frame.sv
// Frame sequencer. It detects the start edge, confirms the start bit at
// mid-bit, shifts in the data LSB first, checks parity, and samples the
// stop bit. done is a one-cycle strobe at the stop-bit sample, and result
// is valid alongside it.
// Assumes: rx is already synchronized. enable low forces idle.
module wurx_frame
    import wurx_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       rx,
    input  logic       nine_bit,
    input  logic [1:0] par_mode,
    output logic       busy,
    output logic       done,
    output rx_result_t result
);
    rx_state_e  state;
    logic       prev;
    logic [3:0] idx;
    logic [8:0] sh;
    logic       par_acc;
    logic       par_bad;
    logic       tick;
    logic       par_on;
    logic       odd_sel;
    logic [3:0] last_idx;

    assign par_on   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign odd_sel  = (par_mode == PAR_ODD);
    assign last_idx = nine_bit ? 4'd8 : 4'd7;

    wurx_baud #(.DIV(DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  ((state == ST_IDLE) || (state == ST_DONE)),
        .half (state == ST_START),
        .tick (tick)
    );

    // Step the sequencer through the bit slots of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            prev    <= 1'b1;
            idx     <= '0;
            sh      <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
        end else begin
            prev <= rx;
            if (!enable) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (prev && !rx) state <= ST_START;
                    ST_START: if (tick) begin
                        if (rx) begin
                            state <= ST_IDLE;
                        end else begin
                            state   <= ST_DATA;
                            idx     <= '0;
                            sh      <= '0;
                            par_acc <= 1'b0;
                            par_bad <= 1'b0;
                        end
                    end
                    ST_DATA: if (tick) begin
                        sh      <= {rx, sh[8:1]};
                        par_acc <= par_acc ^ rx;
                        if (idx == last_idx) state <= par_on ? ST_PAR : ST_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                    ST_PAR: if (tick) begin
                        par_bad <= (par_acc ^ rx) ^ odd_sel;
                        state   <= ST_STOP;
                    end
                    ST_STOP: if (tick) state <= ST_DONE;
                    ST_DONE: state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy           = (state != ST_IDLE);
    assign done           = enable && (state == ST_STOP) && tick;
    assign result.data    = nine_bit ? sh : {1'b0, sh[8:1]};
    assign result.par_err = par_on && par_bad;
    assign result.frm_err = !rx;

    // R8: the done state always hands back to idle on the next cycle
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));

    // R9: a high mid-bit start sample returns to idle
    a_r9_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_START && tick && rx) |=> (state == ST_IDLE));
endmodule

// File: rtl/wake_uart_rx.sv
// Wake-capable UART receiver top. It holds the channel enable, the data
// register, the sticky error flags and the interrupt pulses, and it drives
// the clock request while a frame is in flight in wake mode.
// Assumes: all control inputs are synchronous to clk, and strobes are
// one cycle long.
module wake_uart_rx
    import wurx_pkg::*;
#(
    parameter int DIV         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       chan_start,
    input  logic       chan_stop,
    input  logic       wake_en,
    input  logic       err_route,
    input  logic       err_suppress,
    input  logic       nine_bit,
    input  logic [1:0] par_mode,
    input  logic       data_read,
    input  logic       flag_clear,
    output logic [8:0] rdata,
    output logic       parity_err,
    output logic       frame_err,
    output logic       overrun_err,
    output logic       rx_irq,
    output logic       err_irq,
    output logic       clk_req
);
    logic       chan_on;
    logic       rx_s;
    logic       busy;
    logic       done;
    rx_result_t res;
    logic       unread;
    logic       pe_new, fe_new, ov_new, err_any;

    wurx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    wurx_frame #(.DIV(DIV)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (chan_on),
        .rx      (rx_s),
        .nine_bit(nine_bit),
        .par_mode(par_mode),
        .busy    (busy),
        .done    (done),
        .result  (res)
    );

    assign pe_new  = res.par_err && !err_suppress;
    assign fe_new  = res.frm_err && !err_suppress;
    assign ov_new  = unread && !data_read && !err_suppress;
    assign err_any = pe_new || fe_new || ov_new;

    // Channel enable: opened by the start trigger, closed by the stop trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)          chan_on <= 1'b0;
        else if (chan_stop)  chan_on <= 1'b0;
        else if (chan_start) chan_on <= 1'b1;
    end

    // Data register and the unread marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            unread <= 1'b0;
        end else if (done) begin
            rdata  <= res.data;
            unread <= 1'b1;
        end else if (data_read) begin
            unread <= 1'b0;
        end
    end

    // Sticky error flags: a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_err  <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            parity_err  <= (done && pe_new) || (parity_err  && !flag_clear);
            frame_err   <= (done && fe_new) || (frame_err   && !flag_clear);
            overrun_err <= (done && ov_new) || (overrun_err && !flag_clear);
        end
    end

    // Interrupt pulses, routed by error presence and the routing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq  <= 1'b0;
            err_irq <= 1'b0;
        end else begin
            rx_irq  <= done && !(err_route && err_any);
            err_irq <= done && err_route && err_any;
        end
    end

    assign clk_req = wake_en && busy;

    // R1: a closed channel drops the clock request by the next cycle
    a_r1_closed_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_on |=> !clk_req);

    // R3: no flag rises while suppression was on
    a_r3_suppress_pe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> !$past(err_suppress));
    a_r3_suppress_fe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> !$past(err_suppress));
    a_r3_suppress_ov: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> !$past(err_suppress));

    // R6: overrun only rises over unread data
    a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(unread));

    // R7: one interrupt per frame, each a single-cycle pulse
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_irq && err_irq));
    a_r7_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);
    a_r7_err_gate: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(err_route && !err_suppress));

    // R8: the interrupt cycle still holds the clock request in wake mode
    a_r8_req_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq || err_irq) |-> (clk_req || !wake_en));
endmodule

// File: tb/sim_wake_uart_rx.sv
module sim_wake_uart_rx;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       chan_start = 1'b0, chan_stop = 1'b0;
    logic       wake_en = 1'b0, err_route = 1'b0, err_suppress = 1'b0;
    logic       nine_bit = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       data_read = 1'b0, flag_clear = 1'b0;
    logic [8:0] rdata;
    logic       parity_err, frame_err, overrun_err, rx_irq, err_irq, clk_req;

    int n_cmp = 0;
    int n_bad = 0;
    int rx_cnt = 0;
    int err_cnt = 0;

    always #5 clk = ~clk;

    wake_uart_rx #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .chan_start(chan_start), .chan_stop(chan_stop),
        .wake_en(wake_en), .err_route(err_route), .err_suppress(err_suppress),
        .nine_bit(nine_bit), .par_mode(par_mode),
        .data_read(data_read), .flag_clear(flag_clear),
        .rdata(rdata), .parity_err(parity_err), .frame_err(frame_err),
        .overrun_err(overrun_err), .rx_irq(rx_irq), .err_irq(err_irq),
        .clk_req(clk_req)
    );

    always @(negedge clk) begin
        if (rx_irq)  rx_cnt++;
        if (err_irq) err_cnt++;
    end

    // Vector fields: [15] route, [14] suppress, [13] bad stop,
    // [12] bad parity, [11:10] par_mode, [9] nine_bit, [8:0] data
    localparam logic [15:0] VEC [9] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 9'h0A5},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 9'h1C3},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 9'h03C},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 9'h081},
        {1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 9'h05A},
        {1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 9'h0F0},
        {1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 9'h155},
        {1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 9'h00F},
        {1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 9'h0FF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic send(input logic [8:0] d, input logic nine, input logic [1:0] pm,
                        input logic badpar, input logic badstop);
        logic x;
        int nb;
        nb = nine ? 9 : 8;
        x = nine ? ^d : ^d[7:0];
        rxd = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            rxd = d[b];
            repeat (DIV) @(negedge clk);
        end
        if (pm == 2'b01 || pm == 2'b10) begin
            rxd = ((pm == 2'b01) ? x : !x) ^ badpar;
            repeat (DIV) @(negedge clk);
        end
        rxd = !badstop;
        repeat (DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * DIV) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int rx0, er0;
        logic [8:0] keep;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 rdata", rdata, 0);
        chk("R11 flags", {parity_err, frame_err, overrun_err}, 0);
        chk("R11 irqs", {rx_irq, err_irq}, 0);
        chk("R11 clk_req", clk_req, 0);

        // R1: closed channel after reset ignores a frame
        send(9'h033, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R1 closed rdata", rdata, 0);
        chk("R1 closed irq", rx_cnt, 0);

        pulse(chan_start);

        // Table walk: R2 R4 R5 R3 R7
        for (int i = 0; i < 9; i++) begin
            logic [15:0] v;
            logic pe_x, fe_x, err_x;
            v = VEC[i];
            nine_bit = v[9];
            par_mode = v[11:10];
            err_suppress = v[14];
            err_route = v[15];
            pulse(flag_clear);
            rx0 = rx_cnt;
            er0 = err_cnt;
            send(v[8:0], v[9], v[11:10], v[12], v[13]);
            pe_x = (v[11:10] == 2'b01 || v[11:10] == 2'b10) && v[12] && !v[14];
            fe_x = v[13] && !v[14];
            err_x = pe_x || fe_x;
            chk($sformatf("R2 data vec%0d", i), rdata, v[9] ? v[8:0] : {1'b0, v[7:0]});
            chk($sformatf("R4 parity vec%0d", i), parity_err, pe_x);
            chk($sformatf("R5 framing vec%0d", i), frame_err, fe_x);
            chk($sformatf("R3 overrun vec%0d", i), overrun_err, 0);
            chk($sformatf("R7 rx_irq vec%0d", i), rx_cnt - rx0, (v[15] && err_x) ? 0 : 1);
            chk($sformatf("R7 err_irq vec%0d", i), err_cnt - er0, (v[15] && err_x) ? 1 : 0);
            pulse(data_read);
        end

        // R10: a flag stays until cleared
        nine_bit = 1'b0; par_mode = 2'b00; err_suppress = 1'b0; err_route = 1'b0;
        pulse(flag_clear);
        send(9'h011, 1'b0, 2'b00, 1'b0, 1'b1);
        pulse(data_read);
        repeat (5) @(negedge clk);
        chk("R10 sticky", frame_err, 1);
        pulse(flag_clear);
        chk("R10 cleared", frame_err, 0);

        // R8: clock request edges in wake mode
        wake_en = 1'b1;
        fork
            send(9'h0C6, 1'b0, 2'b00, 1'b0, 1'b0);
            begin
                @(negedge clk);
                @(negedge clk);
                chk("R8 low before rise", clk_req, 0);
                @(negedge clk);
                chk("R8 rise", clk_req, 1);
                repeat (4 * DIV) @(negedge clk);
                chk("R8 mid frame", clk_req, 1);
                seen = 1'b0;
                for (int k = 0; k < 12 * DIV && !seen; k++) begin
                    @(negedge clk);
                    if (rx_irq) seen = 1'b1;
                end
                chk("R8 irq seen", seen, 1);
                chk("R8 high at load", clk_req, 1);
                @(negedge clk);
                chk("R8 fall", clk_req, 0);
            end
        join
        chk("R8 data", rdata, 9'h0C6);
        pulse(data_read);

        // R9: false start aborts
        keep = rdata;
        rx0 = rx_cnt;
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * DIV) @(negedge clk);
        chk("R9 no irq", rx_cnt - rx0, 0);
        chk("R9 rdata kept", rdata, keep);
        chk("R9 clk_req dropped", clk_req, 0);

        // R8: no clock request when wake mode is off
        wake_en = 1'b0;
        seen = 1'b0;
        fork
            send(9'h07E, 1'b0, 2'b00, 1'b0, 1'b0);
            for (int k = 0; k < 12 * DIV; k++) begin
                @(negedge clk);
                if (clk_req) seen = 1'b1;
            end
        join
        chk("R8 stays low", seen, 0);
        pulse(data_read);

        // R6: overrun, new data overwrites
        send(9'h0A1, 1'b0, 2'b00, 1'b0, 1'b0);
        send(9'h0B2, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R6 overrun set", overrun_err, 1);
        chk("R6 overwrite", rdata, 9'h0B2);
        pulse(data_read);
        pulse(flag_clear);
        chk("R10 overrun cleared", overrun_err, 0);

        // R3: overrun suppressed
        err_suppress = 1'b1;
        send(9'h0C3, 1'b0, 2'b00, 1'b0, 1'b0);
        send(9'h0D4, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R3 overrun suppressed", overrun_err, 0);
        chk("R6 overwrite suppressed", rdata, 9'h0D4);
        pulse(data_read);
        err_suppress = 1'b0;

        // R1: stop closes the channel; stop wins over start
        chan_start = 1'b1; chan_stop = 1'b1;
        @(negedge clk);
        chan_start = 1'b0; chan_stop = 1'b0;
        rx0 = rx_cnt;
        send(9'h055, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R1 stopped irq", rx_cnt - rx0, 0);
        chk("R1 stopped rdata", rdata, 9'h0D4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule